// File: doc/BRIEF.md
# GPIO Pin Bank with Interrupt Detection

This block is a bank of general-purpose pins controlled through a word-addressed register interface: one write strobe, a byte address and 32-bit write data. Read data is returned combinationally from the address. Each pin has four registers. The pad register stores pull, function, drive and output-enable settings. The data register carries the synchronized input and the output value. The interrupt register selects polarity, edge or level sensing, and two separate enables. The status register is a write-one-to-clear latch. A fifth register per pin routes the pin's interrupt to the application processor or to nothing.

Pin inputs cross into the clock domain through a two-flop synchronizer. An edge detector compares each synchronized sample with the one before it. Detected events feed two independent paths. The visible status latch is gated by the raw-status enable. The interrupt request is gated only by the interrupt enable. A pin can therefore raise the summary interrupt while its status bit stays clear. The summary interrupt is the OR of the requests of all pins routed to the application processor.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pad, data and interrupt register reads 0, every status bit reads 0, every route register reads 7, `pin_oe` and `pin_out` are 0 and `summary_irq` is 0.
- R2: Per-pin registers of pin p sit at byte address 0x1000 + 0x10·p: pad at +0x0, data at +0x4, interrupt configuration at +0x8, status at +0xC. The route register of pin p sits at 0x400 + 4·p. A read of any other address returns 0.
- R3: The pad register stores bits [9:0] (pull [1:0], function [5:2], drive [8:6], output enable 9) and reads them back. `pin_oe[p]` equals bit 9. `pin_out[p]` carries the data-register output bit when bit 9 is set and is 0 otherwise.
- R4: Data-register bit 0 reads the pin input through a two-flop synchronizer. A change driven before a clock edge is visible after the second edge. Bit 1 holds the written output value.
- R5: In the interrupt register, bit 0 is the enable, bit 1 selects high polarity, bit 2 selects edge mode (0 means level) and bit 3 is the raw-status enable. With bit 1 set, detection is on a rising edge or a high level. With bit 1 clear, detection is on a falling edge or a low level.
- R6: A detected event sets status bit 0 one edge after the synchronized input shows it, and only when the raw-status enable is 1.
- R7: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A clear takes priority over an event in the same cycle. A level event still present sets the status again at the following edge.
- R8: `summary_irq` is the OR over pins of (enable AND route code 4 AND pending). Pending is the live qualified level in level mode. In edge mode it is an edge latch that is set by every detected edge, regardless of the raw-status enable, and is cleared by a status write of 1. The summary can therefore be 1 while the status reads 0.
- R9: A route code other than 4 (for example 7), or a cleared interrupt enable, keeps the pin from driving `summary_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| addr | input | ADDR_W | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Pin output values, 0 when not enabled |
| pin_oe | output | NPINS | Per-pin output enable |
| summary_irq | output | 1 | Combined interrupt to the application processor |

## Verification
The bench builds the block with its defaults: NPINS = 4 and ADDR_W = 13. With four pins, each pin can hold a different mode at the same time: rising edge, falling edge, level with status, and level or edge without status. Every summary check therefore also shows that an idle, unrouted or disabled neighbour adds nothing. The first address past the last pin is decoded, which exercises the range limit of the per-pin window. The same-cycle race between a clear and an active level is driven deliberately, and so is an edge-mode interrupt with the status path disabled.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_W      = 32;
  localparam int BANK_BASE  = 'h1000;
  localparam int ROUTE_BASE = 'h400;
  localparam int PIN_STRIDE = 16;
  localparam int ROUTE_STEP = 4;
  localparam int PAD_W      = 10;
  localparam int ICFG_W     = 4;
  localparam int ROUTE_W    = 3;

  localparam logic [ROUTE_W-1:0] ROUTE_APP  = 3'd4;
  localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;

  typedef struct packed {
    logic       oe;
    logic [2:0] drive;
    logic [3:0] func;
    logic [1:0] pull;
  } pad_cfg_t;

  typedef struct packed {
    logic raw_en;
    logic edge_mode;
    logic pol_hi;
    logic en;
  } irq_cfg_t;

  typedef enum logic [1:0] {
    REG_PAD  = 2'd0,
    REG_DATA = 2'd1,
    REG_ICFG = 2'd2,
    REG_STAT = 2'd3
  } pin_reg_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
  import gpio_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_in,
  input  logic               we_pad,
  input  logic               we_data,
  input  logic               we_icfg,
  input  logic               we_stat,
  input  logic               we_route,
  input  logic [PAD_W-1:0]   wd,
  output pad_cfg_t           pad_q,
  output logic               out_q,
  output irq_cfg_t           icfg_q,
  output logic [ROUTE_W-1:0] route_q,
  output logic               status_q,
  output logic               irq_req,
  output logic               pin_out,
  output logic               pin_oe
);
  logic prev_q, pend_q;
  logic status_d, pend_d;
  logic rise, fall, lvl_hit, edg_hit, evt, clr, pending;

  always_comb begin
    rise     = sync_in & ~prev_q;
    fall     = ~sync_in & prev_q;
    lvl_hit  = icfg_q.pol_hi ? sync_in : ~sync_in;
    edg_hit  = icfg_q.pol_hi ? rise : fall;
    evt      = icfg_q.edge_mode ? edg_hit : lvl_hit;
    clr      = we_stat & wd[0];
    status_d = clr ? 1'b0 : (status_q | (evt & icfg_q.raw_en));
    pend_d   = clr ? 1'b0 : (pend_q | (evt & icfg_q.edge_mode));
    pending  = icfg_q.edge_mode ? pend_q : lvl_hit;
    irq_req  = icfg_q.en & (route_q == ROUTE_APP) & pending;
    pin_oe   = pad_q.oe;
    pin_out  = out_q & pad_q.oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q    <= '0;
      out_q    <= 1'b0;
      icfg_q   <= '0;
      route_q  <= ROUTE_NONE;
      status_q <= 1'b0;
      pend_q   <= 1'b0;
      prev_q   <= 1'b0;
    end else begin
      prev_q   <= sync_in;
      status_q <= status_d;
      pend_q   <= pend_d;
      if (we_pad)   pad_q   <= pad_cfg_t'(wd);
      if (we_data)  out_q   <= wd[1];
      if (we_icfg)  icfg_q  <= irq_cfg_t'(wd[ICFG_W-1:0]);
      if (we_route) route_q <= wd[ROUTE_W-1:0];
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 4,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              summary_irq
);
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [ADDR_W-1:0] bank_off, route_off;
  logic              bank_hit, route_hit;
  logic [IW-1:0]     bank_pin, route_pin;
  pin_reg_e          bank_reg;

  logic [NPINS-1:0]  sync_v, out_v, stat_v, irq_v;
  logic [NPINS-1:0]  st_clr_v, raw_en_v, routed_v;
  pad_cfg_t          pad_a   [NPINS];
  irq_cfg_t          icfg_a  [NPINS];
  logic [ROUTE_W-1:0] route_a [NPINS];

  logic unused_bits;
  assign unused_bits = ^{wdata[REG_W-1:PAD_W], bank_off[ADDR_W-1:4+IW],
                         bank_off[1:0], route_off[ADDR_W-1:2+IW], route_off[1:0]};

  always_comb begin
    bank_off  = addr - ADDR_W'(BANK_BASE);
    route_off = addr - ADDR_W'(ROUTE_BASE);
    bank_hit  = (addr >= ADDR_W'(BANK_BASE)) &&
                (bank_off < ADDR_W'(NPINS * PIN_STRIDE));
    route_hit = (addr >= ADDR_W'(ROUTE_BASE)) &&
                (route_off < ADDR_W'(NPINS * ROUTE_STEP));
    bank_pin  = bank_off[4 +: IW];
    bank_reg  = pin_reg_e'(bank_off[3:2]);
    route_pin = route_off[2 +: IW];
  end

  gpio_bank_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(sync_v)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic sel, we_pad, we_data, we_icfg, we_stat, we_route;
    always_comb begin
      sel      = wr_en & bank_hit & (bank_pin == IW'(i));
      we_pad   = sel & (bank_reg == REG_PAD);
      we_data  = sel & (bank_reg == REG_DATA);
      we_icfg  = sel & (bank_reg == REG_ICFG);
      we_stat  = sel & (bank_reg == REG_STAT);
      we_route = wr_en & route_hit & (route_pin == IW'(i));
    end

    gpio_bank_pin u_pin (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_v[i]),
      .we_pad(we_pad), .we_data(we_data), .we_icfg(we_icfg),
      .we_stat(we_stat), .we_route(we_route), .wd(wdata[PAD_W-1:0]),
      .pad_q(pad_a[i]), .out_q(out_v[i]), .icfg_q(icfg_a[i]),
      .route_q(route_a[i]), .status_q(stat_v[i]), .irq_req(irq_v[i]),
      .pin_out(pin_out[i]), .pin_oe(pin_oe[i])
    );

    always_comb begin
      st_clr_v[i] = we_stat & wdata[0];
      raw_en_v[i] = icfg_a[i].raw_en;
      routed_v[i] = icfg_a[i].en & (route_a[i] == ROUTE_APP);
    end
  end

  always_comb begin
    rdata = '0;
    if (bank_hit) begin
      unique case (bank_reg)
        REG_PAD:  rdata = {{(REG_W-PAD_W){1'b0}}, pad_a[bank_pin]};
        REG_DATA: rdata = {{(REG_W-2){1'b0}}, out_v[bank_pin], sync_v[bank_pin]};
        REG_ICFG: rdata = {{(REG_W-ICFG_W){1'b0}}, icfg_a[bank_pin]};
        REG_STAT: rdata = {{(REG_W-1){1'b0}}, stat_v[bank_pin]};
        default:  rdata = '0;
      endcase
    end else if (route_hit) begin
      rdata = {{(REG_W-ROUTE_W){1'b0}}, route_a[route_pin]};
    end
    summary_irq = |irq_v;
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             summary_irq,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] st_clr_v,
  input logic [NPINS-1:0] stat_v,
  input logic [NPINS-1:0] raw_en_v,
  input logic [NPINS-1:0] routed_v
);
  assert_oe_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  assert_summary_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    summary_irq |-> (routed_v != '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      st_clr_v[i] |=> !stat_v[i]);

    assert_raw_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_v[i]) |-> $past(raw_en_v[i]));
  end
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .summary_irq(summary_irq),
  .pin_out(pin_out), .pin_oe(pin_oe), .st_clr_v(st_clr_v),
  .stat_v(stat_v), .raw_en_v(raw_en_v), .routed_v(routed_v)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 4;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic [NPINS-1:0] pin_in, pin_out, pin_oe;
  logic summary_irq;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  gpio_irq_bank #(.NPINS(NPINS), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .summary_irq(summary_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] a_pin(int p, int r);
    return AW'('h1000 + 16*p + 4*r);
  endfunction
  function automatic logic [AW-1:0] a_route(int p);
    return AW'('h400 + 4*p);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int p = 0; p < NPINS; p++) begin
      rd(a_pin(p, 0), v); chk("R1 pad reset", v, 0);
      rd(a_pin(p, 2), v); chk("R1 icfg reset", v, 0);
      rd(a_pin(p, 3), v); chk("R1 status reset", v, 0);
      rd(a_route(p), v);  chk("R1 route reset", v, 7);
    end
    chk("R1 oe reset", 32'(pin_oe), 0);
    chk("R1 out reset", 32'(pin_out), 0);
    chk("R1 summary reset", 32'(summary_irq), 0);
    rd(a_pin(NPINS, 0), v); chk("R2 unmapped past bank", v, 0);
    rd(AW'('h400 + 4*NPINS), v); chk("R2 unmapped past route", v, 0);
  endtask

  task automatic t_pad();
    logic [31:0] v;
    wr(a_pin(1, 0), 32'hFFFF_F3AB);
    rd(a_pin(1, 0), v); chk("R3 pad readback", v, 32'h3AB);
    rd(a_pin(0, 0), v); chk("R2 neighbour pad untouched", v, 0);
    wr(a_pin(1, 1), 32'h2);
    chk("R3 pin_out driven", 32'(pin_out), 32'h2);
    chk("R3 pin_oe set", 32'(pin_oe), 32'h2);
    rd(a_pin(1, 1), v); chk("R4 output bit readback", v & 32'h2, 32'h2);
    wr(a_pin(1, 0), 32'h1AB);
    chk("R3 pin_out gated", 32'(pin_out), 0);
    chk("R3 pin_oe clear", 32'(pin_oe), 0);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    pin_in[2] = 1'b1;
    tick(1); rd(a_pin(2, 1), v); chk("R4 sync one edge", v & 1, 0);
    tick(1); rd(a_pin(2, 1), v); chk("R4 sync two edges", v & 1, 1);
  endtask

  task automatic t_edge_rise();
    logic [31:0] v;
    wr(a_route(0), 4);
    wr(a_pin(0, 2), 32'hF);
    pin_in[0] = 1'b1;
    tick(2); rd(a_pin(0, 3), v); chk("R6 rise status not yet", v, 0);
    tick(1); rd(a_pin(0, 3), v); chk("R5 rise status set", v, 1);
    chk("R8 rise summary", 32'(summary_irq), 1);
    pin_in[0] = 1'b0;
    tick(3); rd(a_pin(0, 3), v); chk("R5 falling ignored, held", v, 1);
    wr(a_pin(0, 3), 0);
    rd(a_pin(0, 3), v); chk("R7 write 0 no effect", v, 1);
    wr(a_pin(0, 3), 1);
    rd(a_pin(0, 3), v); chk("R7 w1c clears", v, 0);
    chk("R8 summary after clear", 32'(summary_irq), 0);
  endtask

  task automatic t_edge_fall();
    logic [31:0] v;
    wr(a_route(1), 4);
    wr(a_pin(1, 2), 32'hD);
    pin_in[1] = 1'b1;
    tick(3); rd(a_pin(1, 3), v); chk("R5 rise ignored in fall mode", v, 0);
    chk("R8 no summary on rise", 32'(summary_irq), 0);
    pin_in[1] = 1'b0;
    tick(3); rd(a_pin(1, 3), v); chk("R5 fall status set", v, 1);
    chk("R8 fall summary", 32'(summary_irq), 1);
    wr(a_pin(1, 3), 1);
    chk("R8 fall summary cleared", 32'(summary_irq), 0);
  endtask

  task automatic t_level_raw();
    logic [31:0] v;
    wr(a_route(2), 4);
    wr(a_pin(2, 2), 32'hB);
    chk("R8 level summary live", 32'(summary_irq), 1);
    tick(1); rd(a_pin(2, 3), v); chk("R6 level status set", v, 1);
    wr(a_pin(2, 3), 1);
    rd(a_pin(2, 3), v); chk("R7 clear wins same cycle", v, 0);
    tick(1); rd(a_pin(2, 3), v); chk("R7 active level re-sets", v, 1);
    pin_in[2] = 1'b0;
    tick(2); chk("R8 level gone", 32'(summary_irq), 0);
    wr(a_pin(2, 3), 1);
    tick(2); rd(a_pin(2, 3), v); chk("R7 stays clear when inactive", v, 0);
    wr(a_pin(2, 2), 0);
  endtask

  task automatic t_noraw_route();
    logic [31:0] v;
    wr(a_route(3), 4);
    wr(a_pin(3, 2), 32'h3);
    pin_in[3] = 1'b1;
    tick(2); chk("R8 level irq without status", 32'(summary_irq), 1);
    tick(1); rd(a_pin(3, 3), v); chk("R6 no status without raw enable", v, 0);
    wr(a_route(3), 7);
    chk("R9 route none blocks", 32'(summary_irq), 0);
    wr(a_route(3), 4);
    chk("R9 route app restores", 32'(summary_irq), 1);
    wr(a_pin(3, 2), 32'h2);
    chk("R9 enable clear blocks", 32'(summary_irq), 0);
    pin_in[3] = 1'b0;
    tick(3);
    wr(a_pin(3, 2), 32'h7);
    pin_in[3] = 1'b1;
    tick(3); chk("R8 edge irq without status", 32'(summary_irq), 1);
    rd(a_pin(3, 3), v); chk("R6 edge status stays clear", v, 0);
    wr(a_pin(3, 3), 1);
    chk("R8 edge latch cleared by w1c", 32'(summary_irq), 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_pad();
    t_sync();
    t_edge_rise();
    t_edge_fall();
    t_level_raw();
    t_noraw_route();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule